// File: doc/BRIEF.md
# Tag Write Command Checker

This block sits behind the field-gap decoder of a contactless tag. It watches the serial write stream as decoded bits arrive, one per valid strobe, and decides whether the stream is a well-formed request to program one memory block. A stream opens with a two-bit command header. The header either asks for a block write or tells the tag to stop. For a write, the body carries an optional 32-bit password, the lock bit, the 32 data bits and the 3-bit block address. A separate end-of-stream strobe closes the stream.

When the stream ends, the block checks three things: the body length, the password (if password mode is on) and the lock state of the target block. It then gives exactly one outcome. It either emits a one-cycle accept with the address and the 33-bit word to program, or it raises a one-cycle error. The mode register supplies the password-mode flag, the stored password word (the content of block 7) and the lock bits of every block. All of these are plain inputs.

Top module: `tag_write_gate`

## Requirements
- R1: The first two bits after an idle gap form the command header. One cycle after the clock edge that takes the second bit, `opcodeValid` pulses for one cycle and `opcodeOut` shows the two bits, with the first bit received in bit 1.
- R2: Only headers 2'b10 (write) and 2'b11 (stop) are legal. Headers 2'b00 and 2'b01 raise `errorPulse` in the same cycle as `opcodeValid`. The rest of that stream is ignored, and its end produces no pulse.
- R3: Header 2'b11 produces one `stopPulse` in the same cycle as `opcodeValid`, with no error. Any further bits and the stream end produce no write and no error.
- R4: With password mode off, a write body is exactly 36 bits, each sent MSB first: the lock bit, then 32 data bits, then a 3-bit block address. If it is accepted, `writeAccept` pulses one cycle after the edge that takes `streamEnd`. `writeAddr` then holds the address, and `writeWord` holds the lock bit in bit 32 and the data in bits 31:0.
- R5: With password mode on, 32 password bits (MSB first) come before the lock bit, so the body is 68 bits. The write is accepted when those bits equal `storedPwd`.
- R6: In password mode, a password that differs from `storedPwd` in any bit raises `errorPulse` at the stream end, and no write is accepted.
- R7: A body of the wrong length raises `errorPulse` at the stream end, and no write is accepted. This covers a body that is too short, one that is too long, and a stream that ends after a single header bit.
- R8: If the addressed block's bit in `lockBits` is set, `errorPulse` is raised and no write is accepted, whatever lock-bit value the frame carries.
- R9: A `streamEnd` with no bits received since the previous end produces no pulse on any output.
- R10: While `rstN` is low, every output is zero.
- R11: `writeAccept`, `errorPulse` and `stopPulse` are one cycle wide, and at most one of them is high in any cycle. `writeAddr` and `writeWord` change only when a write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitIn | input | 1 | Decoded write bit |
| bitValid | input | 1 | `bitIn` is valid this cycle |
| streamEnd | input | 1 | Write stream has finished (one cycle, never together with `bitValid`) |
| pwdModeEn | input | 1 | Password mode enabled |
| storedPwd | input | 32 | Stored password word |
| lockBits | input | 8 | Lock bit of each block, index = block address |
| opcodeValid | output | 1 | Header decoded this cycle |
| opcodeOut | output | 2 | Last decoded header |
| stopPulse | output | 1 | Stop command received |
| writeAccept | output | 1 | Block write may proceed |
| writeAddr | output | 3 | Address of the accepted write |
| writeWord | output | 33 | Lock bit (bit 32) and data of the accepted write |
| errorPulse | output | 1 | Stream rejected |

## Verification
The assertions check on every cycle that the outcome pulses are single-cycle and mutually exclusive, and that each pulse follows its trigger. They also check that an accepted write never targets a block whose lock bit was set on the evaluating edge, and that an illegal header always carries an error. They cannot see which bits were sent on the line. Only the bench's frames can show the rest: that a password or length mismatch is refused, that the address and word are assembled from the right bit positions, and that stop and bad-header streams swallow their trailing bits.

// File: rtl/wcc_pkg.sv
package wcc_pkg;

  localparam logic [1:0] OP_WRITE = 2'b10;
  localparam logic [1:0] OP_STOP  = 2'b11;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HEAD,
    ST_BODY,
    ST_DRAIN
  } wccState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic takeHead;   // first header bit arrives
    logic decodeOp;   // second header bit arrives
    logic shiftBody;  // body bit arrives
    logic evalBody;   // stream ended after a write header
    logic shortEnd;   // stream ended after one header bit
  } ctrlStrobe_t;

endpackage

// File: rtl/wcc_control.sv
module wcc_control
  import wcc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        bitIn,
  input  logic        bitValid,
  input  logic        streamEnd,
  input  logic        headBit,
  output ctrlStrobe_t strobes
);

  wccState_t state;
  wccState_t stateNext;
  logic [1:0] headNow;

  assign headNow = {headBit, bitIn};

  always_comb begin
    stateNext = state;
    strobes   = '0;
    unique case (state)
      ST_IDLE: begin
        if (!streamEnd && bitValid) begin
          strobes.takeHead = 1'b1;
          stateNext        = ST_HEAD;
        end
      end
      ST_HEAD: begin
        if (streamEnd) begin
          strobes.shortEnd = 1'b1;
          stateNext        = ST_IDLE;
        end else if (bitValid) begin
          strobes.decodeOp = 1'b1;
          stateNext        = (headNow == OP_WRITE) ? ST_BODY : ST_DRAIN;
        end
      end
      ST_BODY: begin
        if (streamEnd) begin
          strobes.evalBody = 1'b1;
          stateNext        = ST_IDLE;
        end else if (bitValid) begin
          strobes.shiftBody = 1'b1;
        end
      end
      ST_DRAIN: begin
        if (streamEnd) begin
          stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= stateNext;
    end
  end

endmodule

// File: rtl/wcc_datapath.sv
module wcc_datapath
  import wcc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int PWD_W  = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    bitIn,
  input  ctrlStrobe_t             strobes,
  input  logic                    pwdModeEn,
  input  logic [PWD_W-1:0]        storedPwd,
  input  logic [(1<<ADDR_W)-1:0]  lockBits,
  output logic                    headBit,
  output logic                    opcodeValid,
  output logic [1:0]              opcodeOut,
  output logic                    stopPulse,
  output logic                    writeAccept,
  output logic [ADDR_W-1:0]       writeAddr,
  output logic [DATA_W:0]         writeWord,
  output logic                    errorPulse
);

  localparam int WORD_W     = DATA_W + 1;
  localparam int BODY_PLAIN = WORD_W + ADDR_W;
  localparam int BODY_PWD   = PWD_W + BODY_PLAIN;
  localparam int CNT_W      = $clog2(BODY_PWD + 1) + 1;

  logic [BODY_PWD-1:0] payload;
  logic [CNT_W-1:0]    bodyCnt;
  logic [1:0]          headNow;
  logic [ADDR_W-1:0]   frameAddr;
  logic [WORD_W-1:0]   frameWord;
  logic [PWD_W-1:0]    framePwd;
  logic [CNT_W-1:0]    expLen;
  logic                lenOk;
  logic                pwdOk;
  logic                lockHit;
  logic                acceptNow;
  logic                rejectNow;
  logic                badHead;

  assign headNow   = {headBit, bitIn};
  assign badHead   = strobes.decodeOp && (headNow != OP_WRITE) && (headNow != OP_STOP);

  // field slicing of the right-aligned body
  assign frameAddr = payload[ADDR_W-1:0];
  assign frameWord = payload[ADDR_W +: WORD_W];
  assign framePwd  = payload[BODY_PLAIN +: PWD_W];

  assign expLen    = pwdModeEn ? CNT_W'(BODY_PWD) : CNT_W'(BODY_PLAIN);
  assign lenOk     = (bodyCnt == expLen);
  assign pwdOk     = !pwdModeEn || (framePwd == storedPwd);
  assign lockHit   = lockBits[frameAddr];
  assign acceptNow = strobes.evalBody && lenOk && pwdOk && !lockHit;
  assign rejectNow = (strobes.evalBody && !acceptNow) || strobes.shortEnd || badHead;

  // header and body capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headBit <= 1'b0;
      payload <= '0;
      bodyCnt <= '0;
    end else begin
      if (strobes.takeHead) begin
        headBit <= bitIn;
        payload <= '0;
        bodyCnt <= '0;
      end else if (strobes.shiftBody) begin
        payload <= {payload[BODY_PWD-2:0], bitIn};
        if (bodyCnt != {CNT_W{1'b1}}) begin
          bodyCnt <= bodyCnt + 1'b1;
        end
      end
    end
  end

  // registered outcomes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opcodeValid <= 1'b0;
      opcodeOut   <= 2'b00;
      stopPulse   <= 1'b0;
      writeAccept <= 1'b0;
      writeAddr   <= '0;
      writeWord   <= '0;
      errorPulse  <= 1'b0;
    end else begin
      opcodeValid <= strobes.decodeOp;
      stopPulse   <= strobes.decodeOp && (headNow == OP_STOP);
      errorPulse  <= rejectNow;
      writeAccept <= acceptNow;
      if (strobes.decodeOp) begin
        opcodeOut <= headNow;
      end
      if (acceptNow) begin
        writeAddr <= frameAddr;
        writeWord <= frameWord;
      end
    end
  end

endmodule

// File: rtl/tag_write_gate.sv
module tag_write_gate
  import wcc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int PWD_W  = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    bitIn,
  input  logic                    bitValid,
  input  logic                    streamEnd,
  input  logic                    pwdModeEn,
  input  logic [PWD_W-1:0]        storedPwd,
  input  logic [(1<<ADDR_W)-1:0]  lockBits,
  output logic                    opcodeValid,
  output logic [1:0]              opcodeOut,
  output logic                    stopPulse,
  output logic                    writeAccept,
  output logic [ADDR_W-1:0]       writeAddr,
  output logic [DATA_W:0]         writeWord,
  output logic                    errorPulse
);

  ctrlStrobe_t strobes;
  logic        headBit;

  wcc_control ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .bitIn     (bitIn),
    .bitValid  (bitValid),
    .streamEnd (streamEnd),
    .headBit   (headBit),
    .strobes   (strobes)
  );

  wcc_datapath #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .PWD_W  (PWD_W)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .bitIn       (bitIn),
    .strobes     (strobes),
    .pwdModeEn   (pwdModeEn),
    .storedPwd   (storedPwd),
    .lockBits    (lockBits),
    .headBit     (headBit),
    .opcodeValid (opcodeValid),
    .opcodeOut   (opcodeOut),
    .stopPulse   (stopPulse),
    .writeAccept (writeAccept),
    .writeAddr   (writeAddr),
    .writeWord   (writeWord),
    .errorPulse  (errorPulse)
  );

endmodule

// File: rtl/wcc_checker.sv
module wcc_checker #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    bitValid,
  input logic                    streamEnd,
  input logic [(1<<ADDR_W)-1:0]  lockBits,
  input logic                    opcodeValid,
  input logic [1:0]              opcodeOut,
  input logic                    stopPulse,
  input logic                    writeAccept,
  input logic [ADDR_W-1:0]       writeAddr,
  input logic [DATA_W:0]         writeWord,
  input logic                    errorPulse
);

  logic [(1<<ADDR_W)-1:0] lockQ;

  always_ff @(posedge clk) begin
    lockQ <= lockBits;
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    $countones({writeAccept, errorPulse, stopPulse}) <= 1);  // R11

  AST_ACCEPT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    writeAccept |=> !writeAccept);  // R11

  AST_ACCEPT_AFTER_END: assert property (@(posedge clk) disable iff (!rstN)
    writeAccept |-> $past(streamEnd));  // R4

  AST_ACCEPT_UNLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    writeAccept |-> !lockQ[writeAddr]);  // R8

  AST_STOP_HEADER: assert property (@(posedge clk) disable iff (!rstN)
    stopPulse |-> (opcodeValid && opcodeOut == 2'b11));  // R3

  AST_BAD_HEADER_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (opcodeValid && !opcodeOut[1]) |-> errorPulse);  // R2

  AST_HEADER_AFTER_BIT: assert property (@(posedge clk) disable iff (!rstN)
    opcodeValid |-> $past(bitValid));  // R1

  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !writeAccept |=> ($stable(writeWord) || writeAccept));  // R11

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !writeAccept |=> ($stable(writeAddr) || writeAccept));  // R11

endmodule

bind tag_write_gate wcc_checker #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .bitValid    (bitValid),
  .streamEnd   (streamEnd),
  .lockBits    (lockBits),
  .opcodeValid (opcodeValid),
  .opcodeOut   (opcodeOut),
  .stopPulse   (stopPulse),
  .writeAccept (writeAccept),
  .writeAddr   (writeAddr),
  .writeWord   (writeWord),
  .errorPulse  (errorPulse)
);

// File: tb/tag_write_gate_tb_top.sv
module tag_write_gate_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bitIn = 1'b0;
  logic        bitValid = 1'b0;
  logic        streamEnd = 1'b0;
  logic        pwdModeEn = 1'b0;
  logic [31:0] storedPwd = 32'h0;
  logic [7:0]  lockBits = 8'h0;
  logic        opcodeValid;
  logic [1:0]  opcodeOut;
  logic        stopPulse;
  logic        writeAccept;
  logic [2:0]  writeAddr;
  logic [32:0] writeWord;
  logic        errorPulse;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;
  logic [2:0]  lastAddr = 3'd0;
  logic [32:0] lastWord = 33'd0;

  always #2.5 clk = ~clk;

  tag_write_gate dut_i (
    .clk(clk), .rstN(rstN), .bitIn(bitIn), .bitValid(bitValid), .streamEnd(streamEnd),
    .pwdModeEn(pwdModeEn), .storedPwd(storedPwd), .lockBits(lockBits),
    .opcodeValid(opcodeValid), .opcodeOut(opcodeOut), .stopPulse(stopPulse),
    .writeAccept(writeAccept), .writeAddr(writeAddr), .writeWord(writeWord),
    .errorPulse(errorPulse)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  // drive at negedge, return at next negedge with outputs settled
  task automatic sendBit(input logic b);
    bitIn = b; bitValid = 1'b1; streamEnd = 1'b0;
    @(negedge clk);
    bitValid = 1'b0;
  endtask

  task automatic endStream();
    streamEnd = 1'b1; bitValid = 1'b0;
    @(negedge clk);
    streamEnd = 1'b0;
  endtask

  task automatic runFrame(input logic [1:0] op, input int deltaLen, input bit pwdGood,
                          input logic lockVal, input logic [31:0] data, input logic [2:0] addr);
    logic bits [0:127];
    int n = 0;
    logic [31:0] sentPwd;
    int bodyLen;
    int expLen;
    bit expAcc;
    string reqTag;
    bits[n++] = op[1];
    bits[n++] = op[0];
    if (op == 2'b10) begin
      sentPwd = pwdGood ? storedPwd : (storedPwd ^ (32'h1 << ($urandom % 32)));
      if (pwdModeEn) for (int i = 31; i >= 0; i--) bits[n++] = sentPwd[i];
      bits[n++] = lockVal;
      for (int i = 31; i >= 0; i--) bits[n++] = data[i];
      for (int i = 2; i >= 0; i--) bits[n++] = addr[i];
    end
    if (deltaLen > 0) for (int i = 0; i < deltaLen; i++) bits[n++] = 1'($urandom);
    else n = n + deltaLen;
    if (n < 0) n = 0;

    for (int i = 0; i < n; i++) begin
      sendBit(bits[i]);
      if (i == 1) begin
        chk(opcodeValid && opcodeOut == {bits[0], bits[1]}, "R1", {opcodeValid, opcodeOut}, {1'b1, bits[0], bits[1]});
        chk(stopPulse == (bits[0] && bits[1]), "R3", stopPulse, bits[0] && bits[1]);
        chk(errorPulse == !bits[0], "R2", errorPulse, !bits[0]);
      end else begin
        chk(!writeAccept && !errorPulse && !stopPulse && !opcodeValid, "R11",
            {writeAccept, errorPulse, stopPulse, opcodeValid}, 0);
      end
    end

    endStream();
    expLen = pwdModeEn ? 68 : 36;
    bodyLen = n - 2;
    expAcc = 1'b0;
    if (n == 0) reqTag = "R9";
    else if (n == 1) reqTag = "R7";
    else if (!bits[0]) reqTag = "R2";
    else if (bits[1]) reqTag = "R3";
    else if (bodyLen != expLen) reqTag = "R7";
    else if (pwdModeEn && !pwdGood) reqTag = "R6";
    else if (lockBits[addr]) reqTag = "R8";
    else begin
      expAcc = 1'b1;
      reqTag = pwdModeEn ? "R5" : "R4";
    end
    if (n >= 2 && bits[0] == 1'b1 && bits[1] == 1'b0) begin
      chk(writeAccept == expAcc, reqTag, writeAccept, expAcc);
      chk(errorPulse == !expAcc, reqTag, errorPulse, !expAcc);
    end else begin
      chk(writeAccept == 1'b0, reqTag, writeAccept, 0);
      chk(errorPulse == (n == 1), reqTag, errorPulse, n == 1);
    end
    chk(stopPulse == 1'b0, "R3", stopPulse, 0);
    if (expAcc) begin
      lastAddr = addr;
      lastWord = {lockVal, data};
    end
    chk(writeAddr == lastAddr, expAcc ? reqTag : "R11", writeAddr, lastAddr);
    chk(writeWord == lastWord, expAcc ? reqTag : "R11", writeWord, lastWord);
    @(negedge clk);
    chk(!writeAccept && !errorPulse && !stopPulse, "R11", {writeAccept, errorPulse, stopPulse}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    void'($urandom(32'd5551));
    storedPwd = 32'hC0DE_5EED;
    repeat (3) @(negedge clk);
    chk({opcodeValid, opcodeOut, stopPulse, writeAccept, writeAddr, writeWord, errorPulse} == 0,
        "R10", {stopPulse, writeAccept, errorPulse}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // idle end
    endStream();
    chk(!writeAccept && !errorPulse && !stopPulse && !opcodeValid, "R9",
        {writeAccept, errorPulse, stopPulse, opcodeValid}, 0);

    // plain write, R4
    runFrame(2'b10, 0, 1, 1'b0, 32'hA5A5_0F0F, 3'd3);
    runFrame(2'b10, 0, 1, 1'b1, 32'hFFFF_FFFF, 3'd7);
    runFrame(2'b10, 0, 1, 1'b0, 32'h0000_0001, 3'd0);
    // length errors, R7
    runFrame(2'b10, -1, 1, 1'b0, 32'h1234_5678, 3'd2);
    runFrame(2'b10, 1, 1, 1'b0, 32'h1234_5678, 3'd2);
    runFrame(2'b10, -36, 1, 1'b0, 32'h0, 3'd0);
    runFrame(2'b10, -37, 1, 1'b0, 32'h0, 3'd0);
    // locked block, R8
    lockBits = 8'b0010_0000;
    runFrame(2'b10, 0, 1, 1'b0, 32'hDEAD_BEEF, 3'd5);
    runFrame(2'b10, 0, 1, 1'b1, 32'hDEAD_BEEF, 3'd5);
    runFrame(2'b10, 0, 1, 1'b1, 32'hDEAD_BEEF, 3'd4);
    // password, R5 and R6
    pwdModeEn = 1'b1;
    runFrame(2'b10, 0, 1, 1'b0, 32'h5555_AAAA, 3'd1);
    runFrame(2'b10, 0, 0, 1'b0, 32'h5555_AAAA, 3'd1);
    runFrame(2'b10, -32, 1, 1'b0, 32'h5555_AAAA, 3'd1);
    pwdModeEn = 1'b0;
    // stop and bad headers, R3 and R2
    runFrame(2'b11, 0, 1, 1'b0, 32'h0, 3'd0);
    runFrame(2'b11, 40, 1, 1'b0, 32'h0, 3'd0);
    runFrame(2'b00, 36, 1, 1'b0, 32'h0, 3'd0);
    runFrame(2'b01, 0, 1, 1'b0, 32'h0, 3'd0);

    // constrained random frames
    for (int k = 0; k < 80; k++) begin
      logic [1:0] op;
      int dl;
      int r = $urandom % 10;
      op = (r < 6) ? 2'b10 : (r < 8) ? 2'b11 : 2'($urandom % 2);
      dl = (($urandom % 4) == 0) ? int'($urandom % 7) - 3 : 0;
      pwdModeEn = 1'($urandom);
      lockBits = 8'($urandom) & 8'($urandom);
      runFrame(op, dl, ($urandom % 5) != 0, 1'($urandom), $urandom, 3'($urandom));
    end
    report();
  end

endmodule